// File: doc/BRIEF.md
# Nested Vectored Interrupt Priority Arbiter

This block sits beside an interrupt source collector and decides which handler a processor should run next. Software programs up to sixteen vector slots. Each slot names one of thirty-two interrupt sources and holds the handler address for that source. The slot number is the priority: slot 0 wins over every other slot. A separate default address serves any source that no enabled slot claims. The collector supplies two words: a raw word of every asserted source, and a masked word of sources that are enabled and routed to the normal interrupt line.

The block tracks a current service level. Level 17 means idle, level 16 is the unvectored default, and levels 0 to 15 are the slots. A handler acknowledges by reading the vector register. That read returns the handler address and moves the service level up to the winning slot. Every level keeps the level it interrupted in a small saved-level stack, so an end-of-service write to the same register goes back exactly one nesting step. The interrupt output is gated so that, while a handler runs, only sources of strictly higher-priority slots can assert it.

The register port uses byte addresses. A read strobe returns data one cycle later with a valid flag. The block uses an asynchronous active-low reset, which is released in step with the clock inside the block.

Top module: `vec_irq_arb`

## Requirements
- R1: After reset every slot address, slot control and the default address read as zero, the interrupt output is low and the service level is idle (17).
- R2: Slot n has its handler address at byte offset 0x100+4n and its control at 0x200+4n. Both can be written and read back. In a control value, bit 5 enables the slot and bits 4:0 give the source number. Control readback returns bits 5:0, and bits above 5 are dropped.
- R3: The default address can be written and read back at byte offset 0x34.
- R4: The gating mask for level L is the set of sources of the enabled slots numbered below L. Level 16 covers all enabled slots, level 17 (idle) covers every source, and the mask follows control writes without delay.
- R5: The interrupt output is registered. In the cycle after any (masked word AND mask of the current level) is nonzero it is high, and otherwise it is low.
- R6: A read of offset 0x30 picks the lowest slot below the current level that is enabled, whose source is set in the raw word. It returns that slot's address and makes that slot the current level.
- R7: If the raw word is nonzero but no enabled slot claims any of its bits, an acknowledge from idle moves to level 16 and returns the default address.
- R8: An acknowledge at idle with an all-zero raw word returns the default address and leaves the level idle.
- R9: An acknowledge that finds nothing above the current level returns the current level's address and leaves the level unchanged.
- R10: A write of any value to offset 0x30 below idle restores the level saved when that level was entered. At idle the write has no effect.
- R11: While a slot is in service, sources of that slot, of lower slots, of disabled slots and of unclaimed sources do not raise the interrupt output. Sources of higher slots do.
- R12: Read data and its valid flag appear exactly one cycle after a read strobe. Unmapped offsets read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Read strobe (acknowledge when at 0x30) |
| bus_wr | input | 1 | Write strobe (end of service when at 0x30) |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | AW | Write data |
| bus_rdata | output | AW | Read data, registered |
| rd_valid | output | 1 | Read data valid, one cycle after bus_rd |
| src_raw | input | NSRC | Raw asserted-source word |
| src_masked | input | NSRC | Enabled, normal-line source word |
| irq_out | output | 1 | Gated interrupt request |

## Verification
The hardest state to reach is a two-deep nesting. In that state the saved-level stack holds two live entries, and the end-of-service writes must unwind it in order: first to the outer slot, then to idle. The stimulus gets there through an acknowledge with one source of a middle slot in the raw word. It then adds a higher slot's source and acknowledges again. After each end-of-service write, the service level is read indirectly through the interrupt output, by presenting masked sources of slots that lie just above and just below the expected level. The raw-only acknowledge path to level 16 is reached with a source that no slot claims. A control write that disables a slot then shows the mask following the change.

// File: rtl/vec_arb_pkg.sv
package vec_arb_pkg;
  localparam logic [11:0] OFS_VECTOR  = 12'h030;
  localparam logic [11:0] OFS_DEFAULT = 12'h034;
  localparam logic [11:0] OFS_ADDR_BASE = 12'h100;
  localparam logic [11:0] OFS_CTRL_BASE = 12'h200;

  // word compare of a byte offset
  function automatic logic same_word(input logic [11:0] a, input logic [11:0] b);
    return a[11:2] == b[11:2];
  endfunction

  // offset inside a table of n words starting at base
  function automatic logic in_table(input logic [11:0] a, input logic [11:0] base,
                                    input int unsigned n);
    logic [12:0] lim;
    lim = {1'b0, base} + 13'(4 * n);
    return ({1'b0, a} >= {1'b0, base}) && ({1'b0, a} < lim);
  endfunction
endpackage

// File: rtl/vec_slot_regs.sv
module vec_slot_regs
  import vec_arb_pkg::*;
#(
  parameter int NSLOT = 16,
  parameter int CW    = 6,
  parameter int AW    = 32,
  localparam int SLW  = $clog2(NSLOT)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [11:0]                wr_addr,
  input  logic [AW-1:0]              wr_data,
  output logic [NSLOT-1:0][AW-1:0]   slot_addr,
  output logic [NSLOT-1:0][CW-1:0]   slot_ctrl,
  output logic [AW-1:0]              dflt_addr
);
  logic addr_region, ctrl_region, dflt_hit;
  logic [SLW-1:0] wr_idx;

  always_comb begin
    addr_region = wr_en && in_table(wr_addr, OFS_ADDR_BASE, NSLOT);
    ctrl_region = wr_en && in_table(wr_addr, OFS_CTRL_BASE, NSLOT);
    dflt_hit    = wr_en && same_word(wr_addr, OFS_DEFAULT);
    wr_idx      = wr_addr[SLW+1:2];
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic          addr_ce, ctrl_ce;
    logic [AW-1:0] addr_d;
    logic [CW-1:0] ctrl_d;

    always_comb begin
      addr_ce = addr_region && (wr_idx == SLW'(s));
      ctrl_ce = ctrl_region && (wr_idx == SLW'(s));
      addr_d  = addr_ce ? wr_data : slot_addr[s];
      ctrl_d  = ctrl_ce ? wr_data[CW-1:0] : slot_ctrl[s];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_addr[s] <= '0;
        slot_ctrl[s] <= '0;
      end else begin
        slot_addr[s] <= addr_d;
        slot_ctrl[s] <= ctrl_d;
      end
    end
  end

  logic [AW-1:0] dflt_d;
  always_comb dflt_d = dflt_hit ? wr_data : dflt_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dflt_addr <= '0;
    else        dflt_addr <= dflt_d;
  end
endmodule

// File: rtl/vec_prio_masks.sv
module vec_prio_masks #(
  parameter int NSLOT = 16,
  parameter int NSRC  = 32,
  localparam int SIW  = $clog2(NSRC),
  localparam int CW   = SIW + 1
) (
  input  logic [NSLOT-1:0][CW-1:0]   slot_ctrl,
  output logic [NSLOT+1:0][NSRC-1:0] lvl_mask
);
  logic [NSLOT-1:0][NSRC-1:0] hot;

  assign lvl_mask[0] = '0;

  for (genvar s = 0; s < NSLOT; s++) begin : g_chain
    logic          en;
    logic [SIW-1:0] src;
    assign en  = slot_ctrl[s][SIW];
    assign src = slot_ctrl[s][SIW-1:0];
    assign hot[s] = en ? (NSRC'(1) << src) : '0;
    assign lvl_mask[s+1] = lvl_mask[s] | hot[s];
  end

  assign lvl_mask[NSLOT+1] = '1;
endmodule

// File: rtl/vec_level_stack.sv
module vec_level_stack #(
  parameter int NSLOT = 16,
  parameter int NSRC  = 32,
  localparam int LVW  = $clog2(NSLOT + 2),
  localparam int IDLE = NSLOT + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ack_en,
  input  logic                       eoi_en,
  input  logic [NSRC-1:0]            src_raw,
  input  logic [NSLOT+1:0][NSRC-1:0] lvl_mask,
  output logic [LVW-1:0]             cur_level,
  output logic [LVW-1:0]             ack_level
);
  logic [IDLE-1:0][LVW-1:0] saved_q, saved_d;
  logic [LVW-1:0]           cur_d;
  logic                     raise;

  // lowest level below the current one whose next-level mask meets the raw word
  always_comb begin
    ack_level = cur_level;
    for (int i = NSLOT; i >= 0; i--) begin
      if ((LVW'(i) < cur_level) && ((src_raw & lvl_mask[i + 1]) != '0))
        ack_level = LVW'(i);
    end
    raise = ack_level < cur_level;
  end

  always_comb begin
    saved_d = saved_q;
    cur_d   = cur_level;
    if (ack_en && raise) begin
      saved_d[ack_level] = cur_level;
      cur_d              = ack_level;
    end else if (eoi_en && (cur_level < LVW'(IDLE))) begin
      cur_d = saved_q[cur_level];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_level <= LVW'(IDLE);
      saved_q   <= '0;
    end else begin
      cur_level <= cur_d;
      saved_q   <= saved_d;
    end
  end
endmodule

// File: rtl/vec_irq_arb.sv
module vec_irq_arb
  import vec_arb_pkg::*;
#(
  parameter int NSLOT = 16,
  parameter int NSRC  = 32,
  parameter int AW    = 32
) (
  input  logic            clk,
  input  logic            arst_n,
  input  logic            bus_rd,
  input  logic            bus_wr,
  input  logic [11:0]     bus_addr,
  input  logic [AW-1:0]   bus_wdata,
  output logic [AW-1:0]   bus_rdata,
  output logic            rd_valid,
  input  logic [NSRC-1:0] src_raw,
  input  logic [NSRC-1:0] src_masked,
  output logic            irq_out
);
  localparam int SIW  = $clog2(NSRC);
  localparam int CW   = SIW + 1;
  localparam int SLW  = $clog2(NSLOT);
  localparam int LVW  = $clog2(NSLOT + 2);
  localparam int IDLE = NSLOT + 1;

  // reset: asynchronous assert, clocked release
  logic [1:0] rst_sync;
  logic       rst_n;
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rst_sync <= '0;
    else         rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n = rst_sync[1];

  logic [NSLOT-1:0][AW-1:0]   slot_addr;
  logic [NSLOT-1:0][CW-1:0]   slot_ctrl;
  logic [AW-1:0]              dflt_addr;
  logic [NSLOT+1:0][NSRC-1:0] lvl_mask;
  logic [LVW-1:0]             cur_level, ack_level;
  logic                       vec_hit, ack_en, eoi_en;

  always_comb begin
    vec_hit = same_word(bus_addr, OFS_VECTOR);
    ack_en  = bus_rd && vec_hit;
    eoi_en  = bus_wr && !bus_rd && vec_hit;
  end

  vec_slot_regs #(.NSLOT(NSLOT), .CW(CW), .AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (bus_wr),
    .wr_addr   (bus_addr),
    .wr_data   (bus_wdata),
    .slot_addr (slot_addr),
    .slot_ctrl (slot_ctrl),
    .dflt_addr (dflt_addr)
  );

  vec_prio_masks #(.NSLOT(NSLOT), .NSRC(NSRC)) u_masks (
    .slot_ctrl (slot_ctrl),
    .lvl_mask  (lvl_mask)
  );

  vec_level_stack #(.NSLOT(NSLOT), .NSRC(NSRC)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_en    (ack_en),
    .eoi_en    (eoi_en),
    .src_raw   (src_raw),
    .lvl_mask  (lvl_mask),
    .cur_level (cur_level),
    .ack_level (ack_level)
  );

  // read mux
  logic [AW-1:0]  rdata_d;
  logic [SLW-1:0] rd_idx;
  always_comb begin
    rd_idx  = bus_addr[SLW+1:2];
    rdata_d = '0;
    if (in_table(bus_addr, OFS_ADDR_BASE, NSLOT))
      rdata_d = slot_addr[rd_idx];
    else if (in_table(bus_addr, OFS_CTRL_BASE, NSLOT))
      rdata_d = AW'(slot_ctrl[rd_idx]);
    else if (same_word(bus_addr, OFS_DEFAULT))
      rdata_d = dflt_addr;
    else if (vec_hit)
      rdata_d = (ack_level < LVW'(NSLOT)) ? slot_addr[ack_level[SLW-1:0]] : dflt_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      rd_valid  <= 1'b0;
    end else begin
      rd_valid <= bus_rd;
      if (bus_rd) bus_rdata <= rdata_d;
    end
  end

  // gated request
  logic irq_d;
  always_comb irq_d = (src_masked & lvl_mask[cur_level]) != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_out <= 1'b0;
    else        irq_out <= irq_d;
  end
endmodule

// File: rtl/vec_irq_arb_chk.sv
module vec_irq_arb_chk #(
  parameter int NSRC = 32,
  parameter int AW   = 32,
  parameter int LVW  = 5,
  parameter int IDLE = 17
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_rd,
  input logic            bus_wr,
  input logic [11:0]     bus_addr,
  input logic [AW-1:0]   bus_rdata,
  input logic            rd_valid,
  input logic [NSRC-1:0] src_raw,
  input logic [NSRC-1:0] src_masked,
  input logic            irq_out,
  input logic [LVW-1:0]  cur_level,
  input logic [AW-1:0]   dflt_addr
);
  logic at_vec;
  assign at_vec = bus_addr[11:2] == 10'h00C;

  p_quiet_without_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (src_masked == '0) |=> !irq_out);

  p_idle_passes_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_level == LVW'(IDLE) && src_masked != '0) |=> irq_out);

  p_read_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> rd_valid);

  p_no_stray_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !rd_valid);

  p_empty_ack_default_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && at_vec && cur_level == LVW'(IDLE) && src_raw == '0)
      |=> (bus_rdata == $past(dflt_addr) && cur_level == LVW'(IDLE)));

  p_ack_only_raises_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && at_vec) |=> (cur_level <= $past(cur_level)));

  p_idle_eoi_noop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_rd && at_vec && cur_level == LVW'(IDLE)) |=> cur_level == LVW'(IDLE));

  p_level_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cur_level <= LVW'(IDLE));
endmodule

bind vec_irq_arb vec_irq_arb_chk #(.NSRC(NSRC), .AW(AW), .LVW(LVW), .IDLE(IDLE)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_rd     (bus_rd),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata),
  .rd_valid   (rd_valid),
  .src_raw    (src_raw),
  .src_masked (src_masked),
  .irq_out    (irq_out),
  .cur_level  (cur_level),
  .dflt_addr  (dflt_addr)
);

// File: tb/vec_irq_arb_test.sv
`timescale 1ns/1ps
module vec_irq_arb_test;
  logic        clk = 1'b0;
  logic        arst_n;
  logic        bus_rd, bus_wr;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        rd_valid;
  logic [31:0] src_raw, src_masked;
  logic        irq_out;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  vec_irq_arb uut (
    .clk(clk), .arst_n(arst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rd_valid(rd_valid), .src_raw(src_raw), .src_masked(src_masked),
    .irq_out(irq_out)
  );

  // monitor: compare returned read data against the scoreboard queue
  always @(negedge clk) begin
    if (arst_n && rd_valid) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R12: unexpected read data %h, expected none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          bad++;
          $display("FAIL %s: read data %h, expected %h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    total++;
    if (irq_out !== e) begin
      bad++;
      $display("FAIL %s: irq_out %b, expected %b", t, irq_out, e);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    arst_n = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    src_raw = '0; src_masked = '0;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk_irq(1'b0, "R1");
    rd(12'h100, 32'h0, "R1");
    rd(12'h23C, 32'h0, "R1");
    rd(12'h034, 32'h0, "R1");
    rd(12'h030, 32'h0, "R1");

    // R3 default address
    wr(12'h034, 32'hDEF0_0000);
    rd(12'h034, 32'hDEF0_0000, "R3");

    // R2 slot programming: slot0 src7, slot3 src9, slot5 src12, slot7 disabled src11
    wr(12'h100, 32'h0000_1000); wr(12'h200, 32'h27);
    wr(12'h10C, 32'h0000_3000); wr(12'h20C, 32'h29);
    wr(12'h114, 32'h0000_5000); wr(12'h214, 32'h2C);
    wr(12'h11C, 32'h0000_7000); wr(12'h21C, 32'h0B);
    rd(12'h20C, 32'h29, "R2");
    rd(12'h114, 32'h5000, "R2");
    wr(12'h224, 32'hFF);
    rd(12'h224, 32'h3F, "R2");
    wr(12'h224, 32'h0);

    // R5 idle level passes any source
    src_masked = 32'h1 << 20;
    chk_irq(1'b1, "R5");
    src_masked = '0;
    chk_irq(1'b0, "R5");

    // R6 acknowledge picks slot 3 over slot 5
    src_raw = (32'h1 << 12) | (32'h1 << 9);
    rd(12'h030, 32'h3000, "R6");
    // R11 in service at slot 3
    src_masked = 32'h1 << 12; chk_irq(1'b0, "R11");
    src_masked = 32'h1 << 11; chk_irq(1'b0, "R11");
    src_masked = 32'h1 << 9;  chk_irq(1'b0, "R11");
    src_masked = 32'h1 << 7;  chk_irq(1'b1, "R11");
    src_masked = '0;

    // R9 nothing higher pending
    src_raw = 32'h1 << 12;
    rd(12'h030, 32'h3000, "R9");

    // R6 nested acknowledge of slot 0
    src_raw = (32'h1 << 7) | (32'h1 << 12);
    rd(12'h030, 32'h1000, "R6");
    src_raw = '0;
    src_masked = 32'h1 << 7; chk_irq(1'b0, "R4");

    // R10 unwind: back to slot 3, then idle
    wr(12'h030, 32'h0);
    src_masked = 32'h1 << 7;  chk_irq(1'b1, "R10");
    src_masked = 32'h1 << 12; chk_irq(1'b0, "R10");
    wr(12'h030, 32'h1234);
    chk_irq(1'b1, "R10");
    wr(12'h030, 32'h0);
    src_masked = 32'h1 << 20; chk_irq(1'b1, "R10");
    rd(12'h030, 32'hDEF0_0000, "R8");
    chk_irq(1'b1, "R8");

    // R7 unclaimed raw source goes to the default level
    src_raw = 32'h1 << 20;
    rd(12'h030, 32'hDEF0_0000, "R7");
    src_masked = 32'h1 << 20; chk_irq(1'b0, "R7");
    src_masked = 32'h1 << 12; chk_irq(1'b1, "R4");
    wr(12'h030, 32'h0);
    src_raw = '0;
    src_masked = 32'h1 << 20; chk_irq(1'b1, "R10");
    src_masked = '0;

    // R12 unmapped offsets
    rd(12'h008, 32'h0, "R12");
    wr(12'h00C, 32'hFFFF_FFFF);
    wr(12'h400, 32'hFFFF_FFFF);
    rd(12'h034, 32'hDEF0_0000, "R12");
    rd(12'h20C, 32'h29, "R12");
    chk_irq(1'b0, "R12");

    // R4 mask follows a control write: disable slot 5
    wr(12'h214, 32'h0C);
    src_raw = 32'h1 << 12;
    rd(12'h030, 32'hDEF0_0000, "R4");
    src_masked = 32'h1 << 12; chk_irq(1'b0, "R4");
    src_masked = 32'h1 << 9;  chk_irq(1'b1, "R4");
    wr(12'h030, 32'h0);
    src_raw = '0; src_masked = '0;

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      total++; bad++;
      $display("FAIL R12: %0d reads unanswered, expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule